// File: doc/BRIEF.md
# DDR PHY Calibration Stage Sequencer

This block starts the calibration stages of a DDR2/DDR3 PHY one after another once reset is released. Each stage is an external sub-unit. The sequencer gives it a single-cycle go pulse, then waits for that unit to answer on its pass line or its fail line. The order of the stages is fixed by the interface and cannot be changed:

1. memory initialization
2. read-strobe phase lock
3. strobe-found
4. write leveling (DDR3 only)
5. MPR read leveling
6. output-clock-delay calibration
7. write calibration
8. read leveling stage 1
9. PRBS read leveling

When the ninth stage passes, the sequencer reports calibration complete. When a stage that is able to fail reports a failure, the sequencer stops in a halt state and keeps that state until the next reset.

Each stage has sticky status flags for start, done and error, where the stage defines them. The current state is available as a 6-bit debug code.

The sequencer is built from these parts:
- An enumerated state machine, `cal_seq_fsm`. Its states are IDLE, INIT, PLOCK, DQSF, WRLVL, MPR, OCLK, WRCAL, RDLVL1, PRBS, DONE and HALT.
- A flag bank, `cal_stage_flags`.
- The top level, which maps the flags onto the status ports.

The state machine has these transitions:
- Reset puts it in IDLE.
- IDLE always moves to INIT.
- A stage state that accepts a pass moves to the next stage state.
- DQSF moves to WRLVL if `is_ddr3` is high, and to MPR otherwise.
- PRBS moves to DONE when it accepts a pass.
- A stage state that accepts a fail moves to HALT.
- DONE and HALT are absorbing: once entered, they are never left until reset.

Top module: `calib_sequencer`

## Requirements
- R1: During reset `seq_state` is 0x00 and every flag and output is low. After reset the stage states run with codes 0x01 to 0x09, in this order: init (go bit 0), phase lock (1), strobe-found (2), write leveling (3), MPR (4), output-clock-delay (5), write calibration (6), read leveling 1 (7), PRBS (8).
- R2: When `is_ddr3` is low (it must be held stable while out of reset), the write-leveling stage is skipped. Its go pulse never fires and `wlv_start`, `wlv_done` and `wlv_err` stay low.
- R3: Each stage gets exactly one `stage_go` pulse, one cycle wide, in the first cycle of its state. At most one go bit is high at any time. The stage's pass and fail lines are accepted from the next cycle onward.
- R4: A stage's start flag rises on the clock edge after its go pulse and then stays high.
- R5: An accepted pass sets that stage's done flag on the same edge that the sequencer moves on. The done flag then stays high.
- R6: An accepted fail on a stage that can fail does three things on the same edge:
  - it sets that stage's error flag;
  - it moves `seq_state` to 0x3F, where it stays, with no further go pulses, no further flags and `cal_complete` low;
  - it makes later pass lines have no effect.

  The stages that can fail are phase lock, strobe-found, write leveling, MPR, write calibration and read leveling 1.
- R7: Fail lines from init, output-clock-delay and PRBS are ignored, and those stages wait for their pass line.
- R8: When a stage's pass and fail lines are high in the same accepted cycle, the fail takes effect.
- R9: `cal_complete` and `seq_state` = 0x3E are set on the edge that accepts the PRBS pass, and they stay set. `cal_complete` is never high while any error flag is high.
- R10: In `rdl_start`, `rdl_done` and `rdl_err`, bit 1 is MPR and bit 0 is read leveling 1. In `prbs_stat`, bit 0 is start and bit 1 is done.
- R11: Pass and fail lines of stages other than the current one have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_ddr3 | input | 1 | 1 selects DDR3 (write leveling runs), 0 selects DDR2 |
| stage_ack | input | 9 | Per-stage pass response, indexed by stage number |
| stage_fail | input | 9 | Per-stage fail response, indexed by stage number |
| stage_go | output | 9 | Per-stage one-cycle start pulse |
| plk_start | output | 1 | Phase lock started |
| plk_done | output | 1 | Phase lock passed |
| plk_err | output | 1 | Phase lock failed |
| dqf_start | output | 1 | Strobe-found started |
| dqf_done | output | 1 | Strobe-found passed |
| dqf_err | output | 1 | Strobe-found failed |
| wlv_start | output | 1 | Write leveling started |
| wlv_done | output | 1 | Write leveling passed |
| wlv_err | output | 1 | Write leveling failed |
| rdl_start | output | 2 | Read-leveling starts: [1] MPR, [0] stage 1 |
| rdl_done | output | 2 | Read-leveling passes: [1] MPR, [0] stage 1 |
| rdl_err | output | 2 | Read-leveling failures: [1] MPR, [0] stage 1 |
| ocd_start | output | 1 | Output-clock-delay started |
| ocd_done | output | 1 | Output-clock-delay passed |
| wcl_start | output | 1 | Write calibration started |
| wcl_done | output | 1 | Write calibration passed |
| wcl_err | output | 1 | Write calibration failed |
| prbs_stat | output | 2 | PRBS read leveling: [0] started, [1] passed |
| cal_complete | output | 1 | Every stage passed |
| seq_state | output | 6 | Encoded current state |

## Verification
The bench runs the sequencer under these conditions:
- both memory types;
- no failure, or a failing response on each of the nine stages in turn;
- with the fail line either alone or paired with a simultaneous pass.

The stage latencies differ from run to run.

A design that does not skip the DDR2 stage would show a write-leveling go pulse and start flag. A design that honours fail lines from the three stages that cannot fail would halt when it should complete. A design that gives pass priority would advance past a stage it should have failed.

Stray pulses on other stages' lines are injected, along with a pass that arrives after a halt. These catch a design that listens to the wrong lines or that leaves the halt state. The order of go pulses, their width and the start-flag latency are all checked cycle by cycle.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
    localparam int NSTG    = 9;
    localparam int STATE_W = 6;
    localparam int IDX_W   = $clog2(NSTG);

    localparam int SG_INIT  = 0;
    localparam int SG_PLOCK = 1;
    localparam int SG_DQSF  = 2;
    localparam int SG_WRLVL = 3;
    localparam int SG_MPR   = 4;
    localparam int SG_OCLK  = 5;
    localparam int SG_WRCAL = 6;
    localparam int SG_RDLV1 = 7;
    localparam int SG_PRBS  = 8;

    // stages whose fail line is honoured
    localparam logic [NSTG-1:0] CAN_FAIL = (NSTG'(1) << SG_PLOCK) | (NSTG'(1) << SG_DQSF)
                                         | (NSTG'(1) << SG_WRLVL) | (NSTG'(1) << SG_MPR)
                                         | (NSTG'(1) << SG_WRCAL) | (NSTG'(1) << SG_RDLV1);

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 6'h00,
        ST_INIT   = 6'h01,
        ST_PLOCK  = 6'h02,
        ST_DQSF   = 6'h03,
        ST_WRLVL  = 6'h04,
        ST_MPR    = 6'h05,
        ST_OCLK   = 6'h06,
        ST_WRCAL  = 6'h07,
        ST_RDLVL1 = 6'h08,
        ST_PRBS   = 6'h09,
        ST_DONE   = 6'h3E,
        ST_HALT   = 6'h3F
    } seq_state_e;
endpackage

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
    import cal_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            is_ddr3,
    input  logic [NSTG-1:0] stage_ack,
    input  logic [NSTG-1:0] stage_fail,
    output seq_state_e      state_q,
    output logic [NSTG-1:0] go,
    output logic [NSTG-1:0] pass_ev,
    output logic [NSTG-1:0] fail_ev
);
    seq_state_e       state_d;
    logic             fresh_q;
    logic             in_stage;
    logic [IDX_W-1:0] cur_idx;
    logic             accept;
    logic             fail_hit;
    logic             pass_hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fresh_q <= (state_d != state_q);
        end
    end

    // decode of the stage that the current state serves
    always_comb begin
        in_stage = 1'b1;
        cur_idx  = '0;
        unique case (state_q)
            ST_INIT:   cur_idx = IDX_W'(SG_INIT);
            ST_PLOCK:  cur_idx = IDX_W'(SG_PLOCK);
            ST_DQSF:   cur_idx = IDX_W'(SG_DQSF);
            ST_WRLVL:  cur_idx = IDX_W'(SG_WRLVL);
            ST_MPR:    cur_idx = IDX_W'(SG_MPR);
            ST_OCLK:   cur_idx = IDX_W'(SG_OCLK);
            ST_WRCAL:  cur_idx = IDX_W'(SG_WRCAL);
            ST_RDLVL1: cur_idx = IDX_W'(SG_RDLV1);
            ST_PRBS:   cur_idx = IDX_W'(SG_PRBS);
            default:   in_stage = 1'b0;
        endcase
    end

    assign accept   = in_stage && !fresh_q;
    assign fail_hit = accept && stage_fail[cur_idx] && CAN_FAIL[cur_idx];
    assign pass_hit = accept && stage_ack[cur_idx] && !fail_hit;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_INIT;
            ST_DONE:   state_d = ST_DONE;
            ST_HALT:   state_d = ST_HALT;
            default: begin
                if (fail_hit) begin
                    state_d = ST_HALT;
                end else if (pass_hit) begin
                    unique case (state_q)
                        ST_INIT:   state_d = ST_PLOCK;
                        ST_PLOCK:  state_d = ST_DQSF;
                        ST_DQSF:   state_d = is_ddr3 ? ST_WRLVL : ST_MPR;
                        ST_WRLVL:  state_d = ST_MPR;
                        ST_MPR:    state_d = ST_OCLK;
                        ST_OCLK:   state_d = ST_WRCAL;
                        ST_WRCAL:  state_d = ST_RDLVL1;
                        ST_RDLVL1: state_d = ST_PRBS;
                        ST_PRBS:   state_d = ST_DONE;
                        default:   state_d = ST_HALT;
                    endcase
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        go      = '0;
        pass_ev = '0;
        fail_ev = '0;
        if (in_stage) begin
            go[cur_idx]      = fresh_q;
            pass_ev[cur_idx] = pass_hit;
            fail_ev[cur_idx] = fail_hit;
        end
    end
endmodule

// File: rtl/cal_stage_flags.sv
module cal_stage_flags
    import cal_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] go,
    input  logic [NSTG-1:0] pass_ev,
    input  logic [NSTG-1:0] fail_ev,
    output logic [NSTG-1:0] start_f,
    output logic [NSTG-1:0] done_f,
    output logic [NSTG-1:0] err_f
);
    for (genvar i = 0; i < NSTG; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_f[i] <= 1'b0;
                done_f[i]  <= 1'b0;
            end else begin
                start_f[i] <= start_f[i] | go[i];
                done_f[i]  <= done_f[i] | pass_ev[i];
            end
        end
        if (CAN_FAIL[i]) begin : g_err
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) err_f[i] <= 1'b0;
                else        err_f[i] <= err_f[i] | fail_ev[i];
            end
        end else begin : g_noerr
            assign err_f[i] = 1'b0;
        end
    end
endmodule

// File: rtl/calib_sequencer.sv
module calib_sequencer
    import cal_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_ddr3,
    input  logic [8:0] stage_ack,
    input  logic [8:0] stage_fail,
    output logic [8:0] stage_go,
    output logic       plk_start,
    output logic       plk_done,
    output logic       plk_err,
    output logic       dqf_start,
    output logic       dqf_done,
    output logic       dqf_err,
    output logic       wlv_start,
    output logic       wlv_done,
    output logic       wlv_err,
    output logic [1:0] rdl_start,
    output logic [1:0] rdl_done,
    output logic [1:0] rdl_err,
    output logic       ocd_start,
    output logic       ocd_done,
    output logic       wcl_start,
    output logic       wcl_done,
    output logic       wcl_err,
    output logic [1:0] prbs_stat,
    output logic       cal_complete,
    output logic [5:0] seq_state
);
    seq_state_e      state_q;
    logic [NSTG-1:0] go, pass_ev, fail_ev;
    logic [NSTG-1:0] start_f, done_f, err_f;

    cal_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_ddr3    (is_ddr3),
        .stage_ack  (stage_ack),
        .stage_fail (stage_fail),
        .state_q    (state_q),
        .go         (go),
        .pass_ev    (pass_ev),
        .fail_ev    (fail_ev)
    );

    cal_stage_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .pass_ev (pass_ev),
        .fail_ev (fail_ev),
        .start_f (start_f),
        .done_f  (done_f),
        .err_f   (err_f)
    );

    assign stage_go     = go;
    assign seq_state    = state_q;
    assign cal_complete = (state_q == ST_DONE);

    assign plk_start = start_f[SG_PLOCK];
    assign plk_done  = done_f[SG_PLOCK];
    assign plk_err   = err_f[SG_PLOCK];
    assign dqf_start = start_f[SG_DQSF];
    assign dqf_done  = done_f[SG_DQSF];
    assign dqf_err   = err_f[SG_DQSF];
    assign wlv_start = start_f[SG_WRLVL];
    assign wlv_done  = done_f[SG_WRLVL];
    assign wlv_err   = err_f[SG_WRLVL];
    assign rdl_start = {start_f[SG_MPR], start_f[SG_RDLV1]};
    assign rdl_done  = {done_f[SG_MPR], done_f[SG_RDLV1]};
    assign rdl_err   = {err_f[SG_MPR], err_f[SG_RDLV1]};
    assign ocd_start = start_f[SG_OCLK];
    assign ocd_done  = done_f[SG_OCLK];
    assign wcl_start = start_f[SG_WRCAL];
    assign wcl_done  = done_f[SG_WRCAL];
    assign wcl_err   = err_f[SG_WRCAL];
    assign prbs_stat = {done_f[SG_PRBS], start_f[SG_PRBS]};

    // init stage flags are not brought out; keep them referenced
    logic unused_init;
    assign unused_init = start_f[SG_INIT] ^ done_f[SG_INIT] ^ err_f[SG_INIT]
                       ^ err_f[SG_OCLK] ^ err_f[SG_PRBS];
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       is_ddr3,
    input logic [8:0] stage_ack,
    input logic [8:0] stage_fail,
    input logic [8:0] stage_go,
    input logic       plk_start,
    input logic       plk_done,
    input logic       plk_err,
    input logic       dqf_start,
    input logic       dqf_done,
    input logic       dqf_err,
    input logic       wlv_start,
    input logic       wlv_done,
    input logic       wlv_err,
    input logic [1:0] rdl_start,
    input logic [1:0] rdl_done,
    input logic [1:0] rdl_err,
    input logic       ocd_start,
    input logic       ocd_done,
    input logic       wcl_start,
    input logic       wcl_done,
    input logic       wcl_err,
    input logic [1:0] prbs_stat,
    input logic       cal_complete,
    input logic [5:0] seq_state
);
    logic any_err;
    assign any_err = plk_err | dqf_err | wlv_err | (|rdl_err) | wcl_err;

    p_go_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stage_go));

    p_go_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_go != 9'd0) |=> ((stage_go & $past(stage_go)) == 9'd0));

    p_start_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ocd_start |=> ocd_start);

    p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (plk_done && wcl_done) |=> (plk_done && wcl_done));

    p_halt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 6'h3F) |=> (seq_state == 6'h3F && !cal_complete && stage_go == 9'd0));

    p_ddr2_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_ddr3 |-> (!wlv_start && !wlv_done && !wlv_err));

    p_complete_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cal_complete |-> (!any_err && prbs_stat == 2'b11));

    p_rdl_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdl_start[0] |-> (rdl_done[1] && rdl_start[1]));
endmodule

bind calib_sequencer cal_seq_chk u_chk (.*);

// File: tb/tb_calib_sequencer.sv
module tb_calib_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_ddr3 = 1'b1;
    logic [8:0] stage_ack = '0, stage_fail = '0;
    logic [8:0] stage_go;
    logic plk_start, plk_done, plk_err, dqf_start, dqf_done, dqf_err;
    logic wlv_start, wlv_done, wlv_err, ocd_start, ocd_done;
    logic wcl_start, wcl_done, wcl_err, cal_complete;
    logic [1:0] rdl_start, rdl_done, rdl_err, prbs_stat;
    logic [5:0] seq_state;

    always #2.5 clk = ~clk;

    calib_sequencer dut (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    int lat [9];
    int tmr [9];
    int ph  [9];
    int bad = -1;
    bit both = 0;
    int got [16];
    int ngot = 0;
    int pend_start = -1;
    bit cc_pend = 0;
    logic [8:0] prev_go = '0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] sv();
        return {prbs_stat[0], rdl_start[0], wcl_start, ocd_start, rdl_start[1],
                wlv_start, dqf_start, plk_start, 1'b0};
    endfunction
    function automatic logic [8:0] dv();
        return {prbs_stat[1], rdl_done[0], wcl_done, ocd_done, rdl_done[1],
                wlv_done, dqf_done, plk_done, 1'b0};
    endfunction
    function automatic logic [8:0] ev();
        return {1'b0, rdl_err[0], wcl_err, 1'b0, rdl_err[1],
                wlv_err, dqf_err, plk_err, 1'b0};
    endfunction
    function automatic bit capable(int s);
        return (s == 1 || s == 2 || s == 3 || s == 4 || s == 6 || s == 7);
    endfunction

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <190000 cycles", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // stage responders and go monitor
    always @(negedge clk) begin
        stage_ack  = '0;
        stage_fail = '0;
        if (!rst_n) begin
            for (int i = 0; i < 9; i++) begin tmr[i] = -1; ph[i] = 0; end
            prev_go = '0; pend_start = -1; cc_pend = 0;
        end else begin
            if (pend_start > 0) chk("R4 start flag after go", 32'(sv()[pend_start]), 32'd1);
            pend_start = -1;
            if (cc_pend) chk("R9 complete after PRBS pass", {cal_complete, seq_state}, {1'b1, 6'h3E});
            cc_pend = 0;
            if (stage_go != 0) begin
                chk("R3 one go bit", 32'($countones(stage_go)), 32'd1);
                chk("R3 go one cycle", 32'(stage_go & prev_go), 32'd0);
                for (int i = 0; i < 9; i++) if (stage_go[i]) begin
                    if (ngot < 16) got[ngot] = i;
                    ngot++;
                    if (i > 0) chk("R4 start low in go cycle", 32'(sv()[i]), 32'd0);
                    pend_start = i;
                end
            end
            prev_go = stage_go;
            for (int i = 0; i < 9; i++) begin
                if (tmr[i] > 0) begin
                    tmr[i]--;
                    if (ph[i] == 0 && tmr[i] == lat[i] - 1) begin
                        // R11 stray pulses on other stages' lines
                        stage_ack[(i + 2) % 9]  = 1'b1;
                        stage_fail[(i + 1) % 9] = 1'b1;
                    end
                end
                if (tmr[i] == 0) begin
                    if (i == bad && ph[i] == 0) begin
                        stage_fail[i] = 1'b1;
                        if (both) begin
                            stage_ack[i] = 1'b1;
                            tmr[i] = -1;
                        end else begin
                            tmr[i] = 2; ph[i] = 1;
                        end
                    end else begin
                        stage_ack[i] = 1'b1;
                        tmr[i] = -1;
                    end
                    if (i == 8 && stage_ack[8] && !(both && bad == 8 && 1'b0)) begin
                        chk("R9 complete low before pass", 32'(cal_complete), 32'd0);
                        cc_pend = 1;
                    end
                end
                if (stage_go[i]) tmr[i] = lat[i];
            end
        end
    end

    task automatic run(bit d3, int b, bit bo, int r);
        int exp_ord [10];
        int nexp = 0;
        int halt_at = -1;
        logic [8:0] es = '0, ed = '0, ee = '0;
        logic [5:0] st_snap;
        @(negedge clk);
        rst_n = 1'b0;
        is_ddr3 = d3; bad = b; both = bo;
        for (int i = 0; i < 9; i++) lat[i] = 1 + ((i * 3 + r) % 5);
        ngot = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset state", {cal_complete, seq_state, stage_go}, 16'd0);
        chk("R1 reset flags", {sv(), dv(), ev()}, 27'd0);
        rst_n = 1'b1;
        for (int s = 0; s < 9; s++) begin
            if (s == 3 && !d3) continue;
            exp_ord[nexp++] = s;
            es[s] = 1'b1;
            if (s == b && capable(s)) begin halt_at = s; ee[s] = 1'b1; break; end
            ed[s] = 1'b1;
        end
        es[0] = 1'b0; ed[0] = 1'b0;
        for (int k = 0; k < 400 && !cal_complete && seq_state != 6'h3F; k++) @(negedge clk);
        repeat (12) @(negedge clk);
        chk("R1 go count", 32'(ngot), 32'(nexp));
        for (int k = 0; k < nexp && k < ngot; k++)
            chk("R1 R2 stage order", 32'(got[k]), 32'(exp_ord[k]));
        chk(d3 ? "R5 R10 start flags" : "R2 start flags", 32'(sv()), 32'(es));
        chk(halt_at < 0 ? "R5 R7 done flags" : "R6 done flags", 32'(dv()), 32'(ed));
        chk(bo ? "R8 error flags" : "R6 error flags", 32'(ev()), 32'(ee));
        if (halt_at < 0) begin
            chk("R7 R9 R11 completes", {cal_complete, seq_state}, {1'b1, 6'h3E});
        end else begin
            st_snap = seq_state;
            chk("R6 halt code", {cal_complete, seq_state}, {1'b0, 6'h3F});
            repeat (20) @(negedge clk);
            chk("R6 frozen", {cal_complete, seq_state, sv(), dv(), ev()},
                {1'b0, st_snap, es, ed, ee});
        end
    endtask

    initial begin
        int r = 0;
        for (int d = 0; d < 2; d++)
            for (int bo = 0; bo < 2; bo++)
                for (int b = -1; b < 9; b++) begin
                    run(bit'(d), b, bit'(bo), r);
                    r++;
                end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule